// File: doc/BRIEF.md
# Test Access Port Controller with Two User Scan Chains

This block is a four-wire serial test port controller in the IEEE 1149.1 style. It decodes the test mode select line on each rising edge of the test clock and walks the standard sixteen-state controller. It also holds a three-bit instruction register and a one-bit bypass register. The current instruction chooses which serial source drives the test data output. One source is a small parallel-capture boundary register, which stands in for the full pin chain. The others are the bypass bit, two externally supplied serial returns for readback and configuration, and two user chains.

For the two user instructions the controller does not shift anything itself. It asserts a per-chain select line and provides a gated data clock that pulses only on the capture and shift edges of a data-register scan. It then routes the matching returned serial bit to the output. This lets logic elsewhere on the chip hang its own scan registers off the port. Capture and update strobes and a run-test/idle flag let that logic know when to load and when to commit its parallel values.

Top module: `jtag_tap_user`

## Requirements
- R1: An asynchronous active-low port reset, or five consecutive test clock rising edges with mode select high, puts the controller in its reset state. That state makes BYPASS the current instruction and clears both user selects.
- R2: The controller follows the standard sixteen-state graph on the rising test clock edge. `tap_idle` is high only in Run-Test/Idle.
- R3: The instruction register is three bits wide and shifts least-significant bit first, from the data input end toward the data output end. The Capture-IR state loads binary 001, so the first three bits seen on the output during an instruction scan are 1, 0, 0.
- R4: The instruction codes are 000 EXTEST, 001 SAMPLE/PRELOAD, 010 USER1, 011 USER2, 100 READBACK, 101 CONFIGURE, 110 reserved and 111 BYPASS. During Shift-DR the output comes from the boundary register for 000 and 001, from `usr_ret1` for 010, from `usr_ret2` for 011, from `rdbk_ret` for 100 and from `cfg_ret` for 101.
- R5: Codes 110 and 111 select the one-bit bypass register. It loads 0 in Capture-DR, so an eight-bit scan returns a 0 followed by the first seven input bits.
- R6: `usr_sel1` is high exactly while USER1 is the current instruction, and `usr_sel2` exactly while USER2 is. The two are never high together.
- R7: `usr_dclk` pulses only under USER1 or USER2, and only on the rising edges that leave Capture-DR or Shift-DR. An n-bit scan gives n+1 pulses, and scans under other instructions give none.
- R8: `tdo` and `tdo_oe` change on the falling test clock edge. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R9: Under EXTEST or SAMPLE/PRELOAD the boundary register loads `pin_cap` in Capture-DR and shifts least-significant bit first. It copies its shift stage to `pin_drv` in Update-DR. `pin_drv` is zero after reset.
- R10: `dr_capture` and `dr_update` are each high for exactly one test clock cycle per data-register scan, in Capture-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for tdo, high in shift states |
| tap_idle | output | 1 | High in Run-Test/Idle |
| dr_capture | output | 1 | High in Capture-DR |
| dr_update | output | 1 | High in Update-DR |
| usr_sel1 | output | 1 | User chain 1 selected |
| usr_sel2 | output | 1 | User chain 2 selected |
| usr_dclk | output | 1 | Gated data clock for user chains |
| usr_ret1 | input | 1 | Serial return from user chain 1 |
| usr_ret2 | input | 1 | Serial return from user chain 2 |
| rdbk_ret | input | 1 | Serial return from readback logic |
| cfg_ret | input | 1 | Serial return from configuration logic |
| pin_cap | input | BSR_W | Parallel values captured by the boundary register |
| pin_drv | output | BSR_W | Parallel values committed by the boundary register |

## Verification
On every cycle, the assertions check these properties:
- the select lines are mutually exclusive and the output enable stays confined to the shift states;
- the gated data clock is never enabled outside a user data scan;
- the update strobe never lasts two cycles;
- the fixed instruction capture pattern and the zero capture of the bypass bit hold;
- a run of five mode-select highs always reaches reset, and reset restores BYPASS.

Only the bench scenarios can show the end-to-end serial results. These are the bit order on the output for each of the eight codes, the exact pulse count of the data clock as seen by a modelled user chain, the boundary value committed to the pins, and the recovery from a loaded user instruction through either reset path.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PA_DR  = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PA_IR  = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  // Codes are fixed: the external tools that drive the port rely on them.
  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 3'b000,
    OP_SAMPLE = 3'b001,
    OP_USER1  = 3'b010,
    OP_USER2  = 3'b011,
    OP_RDBK   = 3'b100,
    OP_CONFIG = 3'b101,
    OP_RSVD   = 3'b110,
    OP_BYPASS = 3'b111
  } tap_op_e;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  state_d = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  state_d = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

  AST_TMS_RUN_RESETS: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == ST_TLR)); // R1

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output tap_op_e    op,
  output logic       ir_tdo
);

  logic [IR_W-1:0] ir_sr;
  logic            sr_cap_en, sr_sh_en, op_upd_en, op_rst_en;

  assign sr_cap_en = (state == ST_CAP_IR);
  assign sr_sh_en  = (state == ST_SH_IR);
  assign op_upd_en = (state == ST_UPD_IR);
  assign op_rst_en = (state == ST_TLR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         ir_sr <= '0;
    else if (sr_cap_en) ir_sr <= IR_CAPTURE_PAT;
    else if (sr_sh_en)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         op <= OP_BYPASS;
    else if (op_rst_en) op <= OP_BYPASS;
    else if (op_upd_en) op <= tap_op_e'(ir_sr);
  end

  assign ir_tdo = ir_sr[0];

  AST_IR_CAPTURE_PAT: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sr == 3'b001)); // R3
  AST_TLR_GIVES_BYPASS: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (op == OP_BYPASS)); // R1

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  tap_op_e          op,
  input  logic [BSR_W-1:0] pin_cap,
  output logic [BSR_W-1:0] pin_drv,
  output logic             byp_tdo,
  output logic             bsr_tdo
);

  logic             byp_q;
  logic [BSR_W-1:0] bsr_sr;
  logic             bsr_sel;
  logic             cap_en, sh_en, upd_en;

  assign bsr_sel = (op == OP_EXTEST) || (op == OP_SAMPLE);
  assign cap_en  = (state == ST_CAP_DR);
  assign sh_en   = (state == ST_SH_DR);
  assign upd_en  = (state == ST_UPD_DR) && bsr_sel;

  // Bypass bit: zero on capture, one-bit delay while shifting.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (cap_en) byp_q <= 1'b0;
    else if (sh_en)  byp_q <= tdi;
  end

  generate
    if (BSR_W > 1) begin : g_bsr_multi
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                  bsr_sr <= '0;
        else if (cap_en && bsr_sel)  bsr_sr <= pin_cap;
        else if (sh_en && bsr_sel)   bsr_sr <= {tdi, bsr_sr[BSR_W-1:1]};
      end
    end else begin : g_bsr_single
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                  bsr_sr <= '0;
        else if (cap_en && bsr_sel)  bsr_sr <= pin_cap;
        else if (sh_en && bsr_sel)   bsr_sr <= tdi;
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      pin_drv <= '0;
    else if (upd_en) pin_drv <= bsr_sr;
  end

  assign byp_tdo = byp_q;
  assign bsr_tdo = bsr_sr[0];

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR) |=> !byp_q); // R5
  AST_PINS_HOLD_OUTSIDE_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
    !$past(upd_en) |-> $stable(pin_drv)); // R9

endmodule

// File: rtl/jtag_tap_user.sv
module jtag_tap_user
  import jtag_tap_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             tap_idle,
  output logic             dr_capture,
  output logic             dr_update,
  output logic             usr_sel1,
  output logic             usr_sel2,
  output logic             usr_dclk,
  input  logic             usr_ret1,
  input  logic             usr_ret2,
  input  logic             rdbk_ret,
  input  logic             cfg_ret,
  input  logic [BSR_W-1:0] pin_cap,
  output logic [BSR_W-1:0] pin_drv
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync;
  logic              rst_n;
  tap_state_e        state;
  tap_op_e           op;
  logic              ir_tdo, byp_tdo, bsr_tdo;
  logic              tdo_d, oe_d;
  logic              dclk_en_d, dclk_en;
  logic              in_shift;

  // Reset: asserted at once, released on the second rising test clock edge.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[SYNC_W-2:0], 1'b1};
  end
  assign rst_n = rst_sync[SYNC_W-1];

  jtag_tap_fsm i_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  jtag_tap_ir i_ir (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .op     (op),
    .ir_tdo (ir_tdo)
  );

  jtag_tap_dr #(.BSR_W(BSR_W)) i_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .tdi     (tdi),
    .state   (state),
    .op      (op),
    .pin_cap (pin_cap),
    .pin_drv (pin_drv),
    .byp_tdo (byp_tdo),
    .bsr_tdo (bsr_tdo)
  );

  assign in_shift = (state == ST_SH_DR) || (state == ST_SH_IR);

  always_comb begin
    if (state == ST_SH_IR) begin
      tdo_d = ir_tdo;
    end else begin
      unique case (op)
        OP_EXTEST, OP_SAMPLE: tdo_d = bsr_tdo;
        OP_USER1:             tdo_d = usr_ret1;
        OP_USER2:             tdo_d = usr_ret2;
        OP_RDBK:              tdo_d = rdbk_ret;
        OP_CONFIG:            tdo_d = cfg_ret;
        default:              tdo_d = byp_tdo;
      endcase
    end
    oe_d = in_shift;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

  // Data clock gate: enable changes only while tck is low, so no glitches.
  assign dclk_en_d = ((state == ST_CAP_DR) || (state == ST_SH_DR)) &&
                     ((op == OP_USER1) || (op == OP_USER2));

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) dclk_en <= 1'b0;
    else        dclk_en <= dclk_en_d;
  end

  assign usr_dclk   = tck & dclk_en;
  assign usr_sel1   = (op == OP_USER1);
  assign usr_sel2   = (op == OP_USER2);
  assign tap_idle   = (state == ST_RTI);
  assign dr_capture = (state == ST_CAP_DR);
  assign dr_update  = (state == ST_UPD_DR);

  AST_OE_IN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> in_shift); // R8
  AST_SELECTS_EXCLUSIVE: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({usr_sel1, usr_sel2})); // R6
  AST_DCLK_IN_USER_SCAN: assert property (@(posedge tck) disable iff (!rst_n)
    dclk_en |-> ((state == ST_CAP_DR || state == ST_SH_DR) && (usr_sel1 || usr_sel2))); // R7
  AST_UPDATE_ONE_CYCLE: assert property (@(posedge tck) disable iff (!rst_n)
    dr_update |=> !dr_update); // R10

endmodule

// File: tb/test_jtag_tap_user.sv
module test_jtag_tap_user;

  localparam int W = 8;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic         trst_n, tms, tdi;
  logic         tdo, tdo_oe, tap_idle, dr_capture, dr_update;
  logic         usr_sel1, usr_sel2, usr_dclk;
  logic         usr_ret1, usr_ret2, rdbk_ret, cfg_ret;
  logic [W-1:0] pin_cap, pin_drv;

  jtag_tap_user #(.BSR_W(W)) i_jtag_tap_user (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .tap_idle(tap_idle),
    .dr_capture(dr_capture), .dr_update(dr_update),
    .usr_sel1(usr_sel1), .usr_sel2(usr_sel2), .usr_dclk(usr_dclk),
    .usr_ret1(usr_ret1), .usr_ret2(usr_ret2),
    .rdbk_ret(rdbk_ret), .cfg_ret(cfg_ret),
    .pin_cap(pin_cap), .pin_drv(pin_drv)
  );

  // Two user chains living outside the controller.
  logic [7:0] u1, u2;
  always @(posedge usr_dclk) begin
    if (usr_sel1) u1 <= dr_capture ? 8'hA5 : {tdi, u1[7:1]};
    if (usr_sel2) u2 <= dr_capture ? 8'h3C : {tdi, u2[7:1]};
  end
  assign usr_ret1 = u1[0];
  assign usr_ret2 = u2[0];

  int dclk_total = 0;
  int upd_total  = 0;
  always @(posedge usr_dclk)  dclk_total <= dclk_total + 1;
  always @(posedge dr_update) upd_total  <= upd_total + 1;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic settle();
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, oe;
    tick(1, 0, o, oe); tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o, oe);
      cap[i] = o;
    end
    tick(1, 0, o, oe); tick(0, 0, o, oe);
  endtask

  task automatic scan_dr(input logic [7:0] din, output logic [7:0] dout, output logic oe_all);
    logic o, oe;
    tick(1, 0, o, oe); tick(0, 0, o, oe); tick(0, 0, o, oe);
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, din[i], o, oe);
      dout[i] = o;
      oe_all &= oe;
    end
    tick(1, 0, o, oe); tick(0, 0, o, oe);
  endtask

  // [12:10] code, [9:2] expected scan-out, [1] sel1, [0] sel2
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 8'h96, 1'b0, 1'b0},
    {3'd1, 8'h96, 1'b0, 1'b0},
    {3'd2, 8'hA5, 1'b1, 1'b0},
    {3'd3, 8'h3C, 1'b0, 1'b1},
    {3'd4, 8'hFF, 1'b0, 1'b0},
    {3'd5, 8'h00, 1'b0, 1'b0},
    {3'd6, 8'hB6, 1'b0, 1'b0},
    {3'd7, 8'hB6, 1'b0, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] cap;
    logic [7:0] dout;
    logic       oe_all, o, oe;
    int         d0, u0;
    trst_n = 0; tms = 1; tdi = 0;
    rdbk_ret = 1; cfg_ret = 0; pin_cap = 8'h96;
    repeat (3) @(posedge tck);
    settle();
    chk("R1 reset sel1", usr_sel1, 0);
    chk("R1 reset sel2", usr_sel2, 0);
    chk("R2 reset idle", tap_idle, 0);
    chk("R8 reset oe", tdo_oe, 0);
    chk("R9 reset pins", pin_drv, 0);
    trst_n = 1;
    repeat (4) tick(1, 0, o, oe);
    chk("R2 tlr not idle", tap_idle, 0);
    tick(0, 0, o, oe);
    settle();
    chk("R2 idle in rti", tap_idle, 1);
    chk("R8 oe low in rti", tdo_oe, 0);

    for (int k = 0; k < 8; k++) begin
      load_ir(VEC[k][12:10], cap);
      settle();
      chk($sformatf("R3 capture pattern code %0d", k), cap, 3'b001);
      chk($sformatf("R6 sel1 code %0d", k), usr_sel1, VEC[k][1]);
      chk($sformatf("R6 sel2 code %0d", k), usr_sel2, VEC[k][0]);
      d0 = dclk_total; u0 = upd_total;
      scan_dr(8'h5B, dout, oe_all);
      settle();
      chk($sformatf("R4 R5 scan out code %0d", k), dout, VEC[k][9:2]);
      chk($sformatf("R8 oe in shift code %0d", k), oe_all, 1);
      chk($sformatf("R7 dclk pulses code %0d", k), dclk_total - d0,
          (VEC[k][12:10] == 3'd2 || VEC[k][12:10] == 3'd3) ? 9 : 0);
      chk($sformatf("R10 update pulses code %0d", k), upd_total - u0, 1);
      if (k == 0) chk("R9 pins committed after EXTEST", pin_drv, 8'h5B);
    end

    // R1: five TMS highs from a user instruction return to bypass
    load_ir(3'd2, cap);
    settle();
    chk("R6 user1 loaded", usr_sel1, 1);
    repeat (5) tick(1, 0, o, oe);
    settle();
    chk("R1 tms run clears sel1", usr_sel1, 0);
    chk("R2 tms run leaves idle", tap_idle, 0);
    tick(0, 0, o, oe);
    scan_dr(8'h5B, dout, oe_all);
    chk("R1 bypass after tms run", dout, 8'hB6);

    // R1: asynchronous port reset clears a user selection at once
    load_ir(3'd3, cap);
    settle();
    chk("R6 user2 loaded", usr_sel2, 1);
    #1 trst_n = 0;
    #1 chk("R1 trst clears sel2", usr_sel2, 0);
    trst_n = 1;
    repeat (3) tick(1, 0, o, oe);
    tick(0, 0, o, oe);
    scan_dr(8'hFF, dout, oe_all);
    chk("R5 bypass after trst", dout, 8'hFE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule